// File: doc/BRIEF.md
# I2C Four-Way Bus Switch Controller

This block is the digital control side of an I2C-controlled switch that connects one upstream bus to one of four downstream buses. It acts as an I2C slave. An upstream master addresses it and writes a control byte, and the block turns that byte into four one-hot channel-enable outputs for the switch. The master can read the byte back. The value returned carries the stored selection and a live interrupt flag for each downstream channel.

The slave address has two parts. The upper bits are a fixed parameter and the lower bits come from three strap inputs, so up to eight of these controllers can share one bus. A new selection is held until the master ends the transaction with a STOP condition. This way a downstream bus is never connected in the middle of a transfer. Four active-low interrupt inputs, one per channel, are merged into one active-low, open-drain-style interrupt output. That output is low whenever any input is low, whatever channel is selected.

SCL and SDA are sampled on a fast system clock through two-flop synchronizers. SDA is driven back only as a pull-low enable.

Top module: `i2cmux_ctrl`

## Requirements
- R1: At most one bit of `chan_en_o` is ever 1.
- R2: Control bit 2 is the enable. If bit 2 is 0, all enables are 0. If bit 2 is 1, bits 1:0 give a channel number k from 0 to 3 in binary, and only `chan_en_o[k]` is 1.
- R3: A written selection does not change `chan_en_o` when the data byte ends. The enables change only in the cycle after a STOP condition (SDA rising while SCL is high) is detected.
- R4: The block acknowledges (pulls SDA low in the ninth clock) only the 7-bit address {ADDR_HI, `addr_pins_i`}, with the R/W bit in bit 0 of the first byte. A transaction to any other address gets no acknowledge and has no effect.
- R5: After reset, `chan_en_o` is 0, SDA is released, and the control bits read back as 0.
- R6: A read returns one byte: bits 7:4 are the interrupt flags for channels 3..0, bit 3 is 0, and bits 2:0 are the stored control bits. It is sent MSB first.
- R7: `irq_n_o` is 0 while any bit of `irq_n_i` is 0, and 1 when all four are 1.
- R8: Only bits 2:0 of a written byte are stored. Bits 7:3 are ignored and bit 3 always reads 0.
- R9: Flag bit 4+k is 1 while `irq_n_i[k]` is 0, for any selected channel. The flags are not latched and clear when the input returns to 1.
- R10: After the master NACKs a read byte, SDA is released, and it stays released after any STOP.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Upstream I2C clock level |
| sda_i | input | 1 | Upstream I2C data level |
| sda_oe_o | output | 1 | 1 pulls SDA low (open-drain drive) |
| addr_pins_i | input | 3 | Strap inputs for the low address bits |
| irq_n_i | input | 4 | Active-low interrupt input per downstream channel |
| chan_en_o | output | 4 | One-hot downstream channel enables |
| irq_n_o | output | 1 | Active-low combined interrupt output |

## Verification
Two functions can act in the same system-clock cycle: the STOP-triggered commit of the pending selection, and a change on an interrupt input. The bench raises SDA for the STOP in the same cycle as it drops an interrupt input. It then checks three things: the new channel enables, the low interrupt output, and a read-back byte in which both the committed select bits and the new flag appear.

// File: rtl/i2cmux_pkg.sv
// Shared constants and types for the I2C bus switch controller.
// Assumes four downstream channels and an 8-bit control byte.
package i2cmux_pkg;
    localparam int NUM_CH = 4;
    localparam int SEL_W  = $clog2(NUM_CH);
    localparam int CTRL_W = SEL_W + 1;
    localparam int BYTE_W = 8;

    typedef logic [CTRL_W-1:0] ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_WDATA,
        ST_ACK,
        ST_RDATA,
        ST_RACK
    } slv_state_t;
endpackage

// File: rtl/i2cmux_sync.sv
// Multi-bit two-flop (or deeper) synchronizer for asynchronous levels.
// Assumes each bit is an independent slow level; RST_VAL sets the reset level.
module i2cmux_sync #(
    parameter int             WIDTH   = 1,
    parameter int             STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    // Shift the input through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < STAGES; s++) stage_q[s] <= RST_VAL;
        end else begin
            stage_q[0] <= d_i;
            for (int s = 1; s < STAGES; s++) stage_q[s] <= stage_q[s-1];
        end
    end

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/i2cmux_busmon.sv
// Bus condition monitor: turns synchronized SCL/SDA levels into one-cycle
// event strobes (SCL edges, START, STOP). Assumes inputs already synchronized.
module i2cmux_busmon (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_s,
    input  logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_evt,
    output logic stop_evt
);
    logic scl_p, sda_p;

    // Hold the previous sample of both lines (idle bus is high).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    // Edge and condition decode; START/STOP need SCL high in both samples.
    always_comb begin
        scl_rise  = scl_s & ~scl_p;
        scl_fall  = ~scl_s & scl_p;
        start_evt = scl_s & scl_p & sda_p & ~sda_s;
        stop_evt  = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2cmux_irq.sv
// Interrupt combiner: active-low AND of the channel inputs for the output pin,
// plus synchronized active-high flags for the read-back byte. No latching.
module i2cmux_irq #(
    parameter int N      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_n_i,
    output logic [N-1:0] flags_o,
    output logic         irq_n_o
);
    logic [N-1:0] irq_n_s;

    i2cmux_sync #(.WIDTH(N), .STAGES(STAGES), .RST_VAL({N{1'b1}})) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (irq_n_i),
        .q_o   (irq_n_s)
    );

    // Flags follow the synchronized inputs; output follows the pins directly.
    always_comb begin
        flags_o = ~irq_n_s;
        irq_n_o = &irq_n_i;
    end
endmodule

// File: rtl/i2cmux_slave.sv
// I2C slave engine: address match, control byte write, read of the merged
// status byte, and STOP-time commit of the selection. Assumes SCL/SDA are
// synchronized and the system clock is many times faster than SCL.
module i2cmux_slave
    import i2cmux_pkg::*;
#(
    parameter int                    ADDR_W  = 7,
    parameter int                    PIN_W   = 3,
    parameter logic [ADDR_W-PIN_W-1:0] ADDR_HI = 4'b1110
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_evt,
    input  logic              stop_evt,
    input  logic [PIN_W-1:0]  addr_pins,
    input  logic [NUM_CH-1:0] flags,
    output ctrl_t             sel_active,
    output logic              sda_oe
);
    localparam int PAD_W = BYTE_W - NUM_CH - CTRL_W;

    slv_state_t        st;
    logic [3:0]        bitcnt;
    logic [BYTE_W-1:0] shreg;
    logic              rw, ack_seen;
    ctrl_t             ctrl_q;
    logic [ADDR_W-1:0] dev_addr;
    logic [BYTE_W-1:0] rd_byte;

    // Device address and the byte returned on reads.
    always_comb begin
        dev_addr = {ADDR_HI, addr_pins};
        rd_byte  = {flags, {PAD_W{1'b0}}, ctrl_q};
    end

    // Transaction sequencer; START and STOP override any state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st         <= ST_IDLE;
            bitcnt     <= '0;
            shreg      <= '0;
            rw         <= 1'b0;
            ack_seen   <= 1'b0;
            ctrl_q     <= '0;
            sel_active <= '0;
            sda_oe     <= 1'b0;
        end else if (start_evt) begin
            st     <= ST_ADDR;
            bitcnt <= '0;
            sda_oe <= 1'b0;
        end else if (stop_evt) begin
            st         <= ST_IDLE;
            sda_oe     <= 1'b0;
            sel_active <= ctrl_q;
        end else begin
            case (st)
                ST_ADDR, ST_WDATA: begin
                    if (scl_rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[BYTE_W-2:0], sda_s};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (scl_fall && bitcnt == 4'd8) begin
                        if (st == ST_ADDR) begin
                            if (shreg[BYTE_W-1:1] == dev_addr) begin
                                sda_oe <= 1'b1;
                                rw     <= shreg[0];
                                st     <= ST_ACK;
                            end else begin
                                st <= ST_IDLE;
                            end
                        end else begin
                            ctrl_q <= shreg[CTRL_W-1:0];
                            sda_oe <= 1'b1;
                            rw     <= 1'b0;
                            st     <= ST_ACK;
                        end
                    end
                end
                ST_ACK: begin
                    if (scl_fall) begin
                        bitcnt <= '0;
                        if (rw) begin
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[BYTE_W-1];
                            st     <= ST_RDATA;
                        end else begin
                            sda_oe <= 1'b0;
                            st     <= ST_WDATA;
                        end
                    end
                end
                ST_RDATA: begin
                    if (scl_fall) begin
                        if (bitcnt == 4'd7) begin
                            sda_oe <= 1'b0;
                            st     <= ST_RACK;
                        end else begin
                            shreg  <= {shreg[BYTE_W-2:0], 1'b0};
                            sda_oe <= ~shreg[BYTE_W-2];
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_RACK: begin
                    if (scl_rise) begin
                        ack_seen <= ~sda_s;
                    end else if (scl_fall) begin
                        if (ack_seen) begin
                            bitcnt <= '0;
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[BYTE_W-1];
                            st     <= ST_RDATA;
                        end else begin
                            st <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/i2cmux_ctrl.sv
// Top of the I2C bus switch controller: synchronizes the bus, runs the slave
// engine and decodes the committed selection into one-hot channel enables.
// Assumes clk is at least ~10x the SCL rate.
module i2cmux_ctrl
    import i2cmux_pkg::*;
#(
    parameter int                    ADDR_W      = 7,
    parameter int                    PIN_W       = 3,
    parameter logic [ADDR_W-PIN_W-1:0] ADDR_HI     = 4'b1110,
    parameter int                    SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe_o,
    input  logic [PIN_W-1:0]  addr_pins_i,
    input  logic [NUM_CH-1:0] irq_n_i,
    output logic [NUM_CH-1:0] chan_en_o,
    output logic              irq_n_o
);
    logic        scl_s, sda_s;
    logic        scl_rise, scl_fall, start_evt, stop_evt;
    logic [NUM_CH-1:0] flags;
    ctrl_t       sel_active;

    i2cmux_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   ({scl_i, sda_i}),
        .q_o   ({scl_s, sda_s})
    );

    i2cmux_busmon u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_evt (start_evt),
        .stop_evt  (stop_evt)
    );

    i2cmux_irq #(.N(NUM_CH), .STAGES(SYNC_STAGES)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .irq_n_i (irq_n_i),
        .flags_o (flags),
        .irq_n_o (irq_n_o)
    );

    i2cmux_slave #(.ADDR_W(ADDR_W), .PIN_W(PIN_W), .ADDR_HI(ADDR_HI)) u_slv (
        .clk        (clk),
        .rst_n      (rst_n),
        .sda_s      (sda_s),
        .scl_rise   (scl_rise),
        .scl_fall   (scl_fall),
        .start_evt  (start_evt),
        .stop_evt   (stop_evt),
        .addr_pins  (addr_pins_i),
        .flags      (flags),
        .sel_active (sel_active),
        .sda_oe     (sda_oe_o)
    );

    // One enable per channel: set only when enabled and the number matches.
    for (genvar k = 0; k < NUM_CH; k++) begin : g_en
        assign chan_en_o[k] = sel_active[CTRL_W-1] &&
                              (sel_active[SEL_W-1:0] == SEL_W'(k));
    end
endmodule

// File: rtl/i2cmux_ctrl_chk.sv
// Property checker for the bus switch controller, bound to the top module.
module i2cmux_ctrl_chk #(
    parameter int N = 4
) (
    input logic         clk,
    input logic         rst_n,
    input logic [N-1:0] chan_en,
    input logic         stop_evt,
    input logic         sda_oe
);
    assert_onehot_en_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(chan_en));

    assert_change_after_stop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (chan_en != $past(chan_en)) |-> $past(stop_evt));

    assert_reset_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (chan_en == '0 && !sda_oe));

    assert_release_on_stop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        stop_evt |=> !sda_oe);
endmodule

bind i2cmux_ctrl i2cmux_ctrl_chk #(.N(i2cmux_pkg::NUM_CH)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_en  (chan_en_o),
    .stop_evt (stop_evt),
    .sda_oe   (sda_oe_o)
);

// File: tb/i2cmux_ctrl_test.sv
// Scoreboard bench: a bit-banged I2C master drives the block, the driver
// pushes expected values, and observed results are popped and compared.
module i2cmux_ctrl_test;
    localparam int H = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1, sda_m = 1'b1;
    logic       sda_oe;
    logic [2:0] pins = 3'b010;
    logic [3:0] irq_n = 4'hF;
    logic [3:0] chan_en;
    logic       irq_out;
    logic       sda_bus;
    logic       done = 1'b0;

    int checks = 0;
    int failures = 0;

    typedef struct { string req; logic [7:0] exp; } item_t;
    item_t sbq[$];

    assign sda_bus = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    i2cmux_ctrl uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_bus),
        .sda_oe_o    (sda_oe),
        .addr_pins_i (pins),
        .irq_n_i     (irq_n),
        .chan_en_o   (chan_en),
        .irq_n_o     (irq_out)
    );

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    // Driver side: queue the expected result.
    task automatic expect_v(string req, logic [7:0] exp);
        item_t it;
        it.req = req;
        it.exp = exp;
        sbq.push_back(it);
    endtask

    // Monitor side: pop the oldest expectation and compare.
    task automatic observe(logic [7:0] act);
        item_t it;
        checks++;
        if (sbq.size() == 0) begin
            failures++;
            $display("FAIL scoreboard empty act=%h exp=none", act);
        end else begin
            it = sbq.pop_front();
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s act=%h exp=%h", it.req, act, it.exp);
            end
        end
    endtask

    task automatic i2c_start();
        sda_m = 1'b1; scl_m = 1'b1; cyc(H);
        sda_m = 1'b0; cyc(H);
        scl_m = 1'b0; cyc(2);
    endtask

    task automatic i2c_stop(logic [3:0] irq_at_stop = 4'hF, logic chg = 1'b0);
        sda_m = 1'b0; cyc(H);
        scl_m = 1'b1; cyc(H);
        sda_m = 1'b1;
        if (chg) irq_n = irq_at_stop;
        cyc(H);
    endtask

    task automatic put_bit(logic b);
        sda_m = b; cyc(H);
        scl_m = 1'b1; cyc(H);
        scl_m = 1'b0; cyc(2);
    endtask

    task automatic get_bit(output logic b);
        sda_m = 1'b1; cyc(H);
        scl_m = 1'b1; cyc(H/2);
        b = sda_bus; cyc(H/2);
        scl_m = 1'b0; cyc(2);
    endtask

    task automatic put_byte(logic [7:0] v, output logic ack);
        logic b;
        for (int i = 7; i >= 0; i--) put_bit(v[i]);
        get_bit(b);
        ack = ~b;
    endtask

    task automatic get_byte(output logic [7:0] v);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b);
            v[i] = b;
        end
    endtask

    function automatic logic [6:0] dev(logic [2:0] p);
        return {4'b1110, p};
    endfunction

    // Write one control byte; address and data acks checked (R4).
    task automatic wr_ctrl(logic [6:0] a, logic [7:0] d, logic do_stop);
        logic ack;
        i2c_start();
        put_byte({a, 1'b0}, ack);
        expect_v("R4 addr ack", 8'h01);
        observe({7'b0, ack});
        put_byte(d, ack);
        expect_v("R4 data ack", 8'h01);
        observe({7'b0, ack});
        if (do_stop) i2c_stop();
    endtask

    // Read nbytes bytes; the last is NACKed and SDA release checked (R10).
    task automatic rd_ctrl(int nbytes, logic [7:0] exp, string req);
        logic ack;
        logic [7:0] v;
        i2c_start();
        put_byte({dev(pins), 1'b1}, ack);
        expect_v("R4 read addr ack", 8'h01);
        observe({7'b0, ack});
        for (int n = 0; n < nbytes; n++) begin
            get_byte(v);
            expect_v(req, exp);
            observe(v);
            put_bit(n == nbytes - 1);
        end
        expect_v("R10 sda released after nack", 8'h00);
        observe({7'b0, sda_oe});
        i2c_stop();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog act=timeout exp=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic ack;
        cyc(10);
        rst_n = 1'b1;
        cyc(4);

        // R5: reset state.
        expect_v("R5 enables after reset", 8'h00); observe({4'b0, chan_en});
        expect_v("R5 sda after reset", 8'h00);     observe({7'b0, sda_oe});
        expect_v("R7 irq idle high", 8'h01);       observe({7'b0, irq_out});
        rd_ctrl(1, 8'h00, "R5 readback after reset");

        // R3: selection pending until STOP; R2: decode after STOP.
        wr_ctrl(dev(pins), 8'h05, 1'b0);
        cyc(H);
        expect_v("R3 no change before stop", 8'h00); observe({4'b0, chan_en});
        i2c_stop();
        expect_v("R2 channel 1 after stop", 8'h02); observe({4'b0, chan_en});
        rd_ctrl(2, 8'h05, "R6 readback two bytes");

        // R1/R2: every channel number.
        for (int k = 0; k < 4; k++) begin
            wr_ctrl(dev(pins), 8'h04 | 8'(k), 1'b1);
            expect_v("R1 R2 one-hot enable", 8'(1 << k)); observe({4'b0, chan_en});
        end

        // R8 and R2: upper bits ignored, bit 2 clear disables.
        wr_ctrl(dev(pins), 8'hFB, 1'b1);
        expect_v("R2 disabled with bit2 low", 8'h00); observe({4'b0, chan_en});
        rd_ctrl(1, 8'h03, "R8 upper bits dropped");
        wr_ctrl(dev(pins), 8'h0E, 1'b1);
        rd_ctrl(1, 8'h06, "R8 bit3 reads zero");
        expect_v("R2 channel 2", 8'h04); observe({4'b0, chan_en});

        // R4: wrong address is not acknowledged and changes nothing.
        i2c_start();
        put_byte({dev(pins ^ 3'b001), 1'b0}, ack);
        expect_v("R4 wrong address nack", 8'h00); observe({7'b0, ack});
        put_byte(8'h04, ack);
        i2c_stop();
        expect_v("R4 no effect from other address", 8'h04); observe({4'b0, chan_en});

        // R4: new strap value moves the address.
        pins = 3'b101;
        cyc(H);
        wr_ctrl(dev(pins), 8'h07, 1'b1);
        expect_v("R4 strap address channel 3", 8'h08); observe({4'b0, chan_en});
        wr_ctrl(dev(pins), 8'h06, 1'b1);

        // R7/R9: flags live, independent of selection, not latched.
        irq_n = 4'b1011; cyc(4);
        expect_v("R7 irq low on ch2", 8'h00); observe({7'b0, irq_out});
        rd_ctrl(1, 8'h46, "R9 flag ch2 while ch2 selected");
        irq_n = 4'b1110; cyc(4);
        rd_ctrl(1, 8'h16, "R9 flag ch0 while ch2 selected");
        irq_n = 4'b0000; cyc(4);
        rd_ctrl(1, 8'hF6, "R6 all flags");
        irq_n = 4'b1111; cyc(4);
        expect_v("R7 irq released", 8'h01); observe({7'b0, irq_out});
        rd_ctrl(1, 8'h06, "R9 flags clear without software");

        // Same-cycle STOP commit and interrupt change (R3, R7, R6).
        wr_ctrl(dev(pins), 8'h05, 1'b0);
        i2c_stop(4'b0111, 1'b1);
        expect_v("R3 commit with irq change", 8'h02); observe({4'b0, chan_en});
        expect_v("R7 irq low with commit", 8'h00);    observe({7'b0, irq_out});
        rd_ctrl(1, 8'h85, "R6 merged byte after concurrent events");
        irq_n = 4'hF;
        cyc(H);
        expect_v("R10 sda idle at end", 8'h00); observe({7'b0, sda_oe});

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule